// File: doc/BRIEF.md
# Thermally Guarded Grayscale PWM Controller

This block turns a bank of per-channel 12-bit brightness values into on/off enables for constant-current sinks. A grayscale tick arrives as a one-cycle enable in the system clock domain. While blanking is high the outputs stay off and the block arms a new PWM cycle. The first tick after blanking falls sets the counter to 1, and each later tick advances it up to 4096. A channel is lit while the count does not exceed its value. After the last count the counter parks until blanking is raised and lowered again.

Brightness values enter through a valid/ready write port into a shadow bank. A separate load strobe copies the whole shadow bank into the active bank, and it takes effect only while blanking is high, so a running cycle is never disturbed. Two comparator inputs carry over-temperature states with hysteresis already applied: a shutdown indication and an early warning. Shutdown removes every output in the same cycle and latches the running cycle off. Either status bit drives an active-low error line, modelled as a drive enable. A pre-charge pull-up enable follows blanking, with a programmable turn-on delay and an immediate turn-off.

Top module: `pwm_fault_ctrl`

## Requirements
- R1: After reset all channel outputs are 0. Both thermal status bits, the error drive and the pre-charge enable are 0, and the write port is ready.
- R2: A write beat (channel index, 12-bit value) is taken into the shadow bank on a clock edge where valid and ready are both 1. Ready is 0 in any cycle where the load strobe is 1 and 1 otherwise.
- R3: The load strobe copies every shadow value to the active bank only when blanking is 1 at that edge. A strobe given with blanking 0 leaves the active values, and so the outputs, unchanged.
- R4: While blanking is 1 every output is 0. After blanking falls, outputs stay 0 until the first grayscale tick, which sets the count to 1.
- R5: Channel n is 1 while the cycle runs and its count is less than or equal to its active value. A value of 0 keeps the channel at 0 for the whole cycle.
- R6: Once the count has reached 4096 all outputs are 0, and further ticks start nothing until blanking is raised and lowered again.
- R7: While the shutdown input is 1 every output is 0 in that same cycle, with no clock edge needed. The thermal error bit reads 1 from the next edge onward.
- R8: The thermal error bit returns to 0 one edge after the shutdown input falls. An interrupted cycle is not resumed: a new cycle starts only on a tick after blanking has been high and then low, with both the shutdown input and the error bit at 0.
- R9: The warning bit is 1 from the edge after the warning input rises and 0 from the edge after it falls. It has no effect on the channel outputs.
- R10: The error drive enable is 1 exactly while the thermal error bit or the warning bit is 1.
- R11: The pre-charge enable becomes 1 after PRE_DELAY consecutive edges with blanking 1 (default 4). It goes to 0 in the same cycle blanking falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank | input | 1 | Blanking: 1 forces outputs off and arms a cycle |
| gs_tick | input | 1 | One-cycle grayscale clock enable |
| gs_wr_valid | input | 1 | Write beat valid |
| gs_wr_ready | output | 1 | Write beat ready (0 during load strobe) |
| gs_wr_chan | input | 4 | Channel index of the write beat |
| gs_wr_value | input | 12 | Brightness value of the write beat |
| gs_load | input | 1 | Copy the shadow bank to the active bank (blanking only) |
| tsd_hot | input | 1 | Shutdown comparator, hysteresis applied |
| warn_hot | input | 1 | Warning comparator, hysteresis applied |
| ch_on | output | 16 | Per-channel sink enable |
| therm_err | output | 1 | Thermal error status bit |
| warn_flag | output | 1 | Temperature warning status bit |
| err_drive | output | 1 | 1 = pull the error line low, 0 = released |
| precharge_en | output | 1 | Pre-charge pull-up enable |

## Verification
The assertions assume that every input is synchronous to the system clock, that gs_tick is a single-cycle enable, and that the comparator inputs are already clean levels, free of glitches. The bench changes all inputs one nanosecond after a rising edge and samples shortly after the edge that follows. Each tick is a pulse exactly one clock wide. The shutdown input is the only signal the bench checks without a clock edge in between, because the output gating it drives has no register.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/gs_bank.sv
module gs_bank #(
  parameter int CHANNELS = 16,
  parameter int GS_BITS  = 12,
  parameter int IW       = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              blank,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [IW-1:0]                     wr_chan,
  input  logic [GS_BITS-1:0]                wr_value,
  input  logic                              load,
  output logic [CHANNELS-1:0][GS_BITS-1:0]  active
);
  logic [CHANNELS-1:0][GS_BITS-1:0] shadow;
  logic                             wr_fire;
  logic                             load_ok;

  assign wr_ready = ~load;
  assign wr_fire  = wr_valid & wr_ready;
  assign load_ok  = load & blank;

  for (genvar n = 0; n < CHANNELS; n++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[n] <= '0;
        active[n] <= '0;
      end else begin
        if (wr_fire && wr_chan == IW'(n)) shadow[n] <= wr_value;
        if (load_ok) active[n] <= shadow[n];
      end
    end
  end

  p_frozen_unblanked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |=> $stable(active));
  p_ready_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wr_ready);
endmodule

// File: rtl/pwm_sequencer.sv
module pwm_sequencer
  import pwm_fault_pkg::*;
#(
  parameter int GS_BITS = 12,
  parameter int CW      = GS_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic          tick,
  input  logic          fault,
  output logic          running,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_LAST = {1'b1, {GS_BITS{1'b0}}};

  seq_state_e state, state_nx;
  logic [CW-1:0] count_nx;

  always_comb begin
    state_nx = state;
    count_nx = count;
    if (blank) begin
      state_nx = SEQ_ARMED;
      count_nx = '0;
    end else begin
      unique case (state)
        SEQ_ARMED: if (tick && !fault) begin
          state_nx = SEQ_RUN;
          count_nx = CW'(1);
        end
        SEQ_RUN: begin
          if (fault) state_nx = SEQ_DONE;
          else if (tick) begin
            if (count == CNT_LAST) state_nx = SEQ_DONE;
            else count_nx = count + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      count <= '0;
    end else begin
      state <= state_nx;
      count <= count_nx;
    end
  end

  assign running = (state == SEQ_RUN);

  p_count_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count != '0 && count <= CNT_LAST));
  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DONE && !blank) |=> (state == SEQ_DONE));
  p_no_start_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_ARMED && fault) |=> !running);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic tsd_hot,
  input  logic warn_hot,
  output logic therm_err,
  output logic warn_flag,
  output logic err_drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_err <= 1'b0;
      warn_flag <= 1'b0;
    end else begin
      therm_err <= tsd_hot;
      warn_flag <= warn_hot;
    end
  end

  assign err_drive = therm_err | warn_flag;

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_hot |=> therm_err);
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tsd_hot |=> !therm_err);
  p_warn_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_hot) |=> warn_flag);
  p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_hot || warn_hot) |=> err_drive);
endmodule

// File: rtl/precharge_timer.sv
module precharge_timer #(
  parameter int PRE_DELAY = 4,
  parameter int PW        = $clog2(PRE_DELAY + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blank,
  output logic precharge_en
);
  localparam logic [PW-1:0] LIMIT = PW'(PRE_DELAY);

  logic [PW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (!blank) wait_cnt <= '0;
    else if (wait_cnt != LIMIT) wait_cnt <= wait_cnt + PW'(1);
  end

  assign precharge_en = blank & (wait_cnt == LIMIT);

  p_off_unblanked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> !precharge_en);
endmodule

// File: rtl/pwm_fault_ctrl.sv
module pwm_fault_ctrl #(
  parameter int CHANNELS  = 16,
  parameter int GS_BITS   = 12,
  parameter int PRE_DELAY = 4,
  parameter int IW        = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blank,
  input  logic                gs_tick,
  input  logic                gs_wr_valid,
  output logic                gs_wr_ready,
  input  logic [IW-1:0]       gs_wr_chan,
  input  logic [GS_BITS-1:0]  gs_wr_value,
  input  logic                gs_load,
  input  logic                tsd_hot,
  input  logic                warn_hot,
  output logic [CHANNELS-1:0] ch_on,
  output logic                therm_err,
  output logic                warn_flag,
  output logic                err_drive,
  output logic                precharge_en
);
  localparam int CW = GS_BITS + 1;

  logic [CHANNELS-1:0][GS_BITS-1:0] active;
  logic                             running;
  logic [CW-1:0]                    count;
  logic                             fault;

  assign fault = tsd_hot | therm_err;

  gs_bank #(.CHANNELS(CHANNELS), .GS_BITS(GS_BITS), .IW(IW)) i_bank (
    .clk(clk), .rst_n(rst_n), .blank(blank),
    .wr_valid(gs_wr_valid), .wr_ready(gs_wr_ready),
    .wr_chan(gs_wr_chan), .wr_value(gs_wr_value),
    .load(gs_load), .active(active));

  pwm_sequencer #(.GS_BITS(GS_BITS), .CW(CW)) i_seq (
    .clk(clk), .rst_n(rst_n), .blank(blank), .tick(gs_tick),
    .fault(fault), .running(running), .count(count));

  thermal_guard i_therm (
    .clk(clk), .rst_n(rst_n), .tsd_hot(tsd_hot), .warn_hot(warn_hot),
    .therm_err(therm_err), .warn_flag(warn_flag), .err_drive(err_drive));

  precharge_timer #(.PRE_DELAY(PRE_DELAY)) i_pre (
    .clk(clk), .rst_n(rst_n), .blank(blank), .precharge_en(precharge_en));

  for (genvar n = 0; n < CHANNELS; n++) begin : g_cmp
    assign ch_on[n] = running & ~fault & ~blank & (active[n] != '0) &
                      (count <= {1'b0, active[n]});
  end

  p_blank_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (ch_on == '0));
  p_shutdown_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_hot |-> (ch_on == '0));
  p_err_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_err |-> (ch_on == '0));
endmodule

// File: tb/test_pwm_fault_ctrl.sv
module test_pwm_fault_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blank = 1'b0, gs_tick = 1'b0, gs_wr_valid = 1'b0, gs_load = 1'b0;
  logic        tsd_hot = 1'b0, warn_hot = 1'b0;
  logic [3:0]  gs_wr_chan = '0;
  logic [11:0] gs_wr_value = '0;
  logic        gs_wr_ready, therm_err, warn_flag, err_drive, precharge_en;
  logic [15:0] ch_on;

  int n_cmp = 0;
  int n_bad = 0;
  int cur   = 0;

  always #2 clk = ~clk;

  pwm_fault_ctrl i_pwm_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .blank(blank), .gs_tick(gs_tick),
    .gs_wr_valid(gs_wr_valid), .gs_wr_ready(gs_wr_ready),
    .gs_wr_chan(gs_wr_chan), .gs_wr_value(gs_wr_value), .gs_load(gs_load),
    .tsd_hot(tsd_hot), .warn_hot(warn_hot), .ch_on(ch_on),
    .therm_err(therm_err), .warn_flag(warn_flag), .err_drive(err_drive),
    .precharge_en(precharge_en));

  // Count values reached after cycle start, with the expected mask when
  // channel n holds n*273 (channel 0 holds 0).
  localparam int          NVEC = 6;
  localparam int          VEC_CNT  [NVEC] = '{1, 273, 274, 2000, 4095, 4096};
  localparam logic [15:0] VEC_MASK [NVEC] = '{16'hFFFE, 16'hFFFE, 16'hFFFC,
                                              16'hFF00, 16'h8000, 16'h0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    gs_tick = 1'b1;
    step();
    gs_tick = 1'b0;
    cur++;
  endtask

  task automatic write_beat(input int ch, input int val);
    gs_wr_valid = 1'b1;
    gs_wr_chan  = 4'(ch);
    gs_wr_value = 12'(val);
    step();
    gs_wr_valid = 1'b0;
  endtask

  task automatic load_pulse(input string req);
    gs_load = 1'b1;
    #1;
    chk(req, 32'(gs_wr_ready), 32'd0);
    step();
    gs_load = 1'b0;
  endtask

  task automatic restart();
    blank = 1'b1;
    step();
    blank = 1'b0;
    step();
    cur = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 ch_on", 32'(ch_on), 32'd0);
    chk("R1 flags", {therm_err, warn_flag, err_drive, precharge_en}, 32'd0);
    chk("R1 ready", 32'(gs_wr_ready), 32'd1);

    // R11 pre-charge delay
    blank = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R11 delay", 32'(precharge_en), (k == 4) ? 32'd1 : 32'd0);
    end
    chk("R4 blanked", 32'(ch_on), 32'd0);

    // R2 writes and R3 load while blanked
    for (int ch = 0; ch < 16; ch++) write_beat(ch, ch * 273);
    load_pulse("R2 ready");
    blank = 1'b0;
    #1;
    chk("R11 immediate off", 32'(precharge_en), 32'd0);
    step();
    chk("R4 no tick yet", 32'(ch_on), 32'd0);

    // Table walk: R5 compare and R6 end of cycle
    cur = 0;
    for (int i = 0; i < NVEC; i++) begin
      while (cur < VEC_CNT[i]) tick();
      chk((i == NVEC - 1) ? "R6 last count" : "R5 mask", 32'(ch_on), 32'(VEC_MASK[i]));
    end
    tick(); tick();
    chk("R6 hold", 32'(ch_on), 32'd0);

    // R3 load ignored while unblanked
    write_beat(15, 0);
    load_pulse("R2 ready2");
    restart();
    tick();
    chk("R3 load ignored", 32'(ch_on), 32'hFFFE);

    // R7 / R8 shutdown mid-cycle
    tick(); tick();
    tsd_hot = 1'b1;
    #1;
    chk("R7 immediate off", 32'(ch_on), 32'd0);
    step();
    chk("R7 error set", {therm_err, err_drive}, 32'd3);
    tick();
    chk("R7 held off", 32'(ch_on), 32'd0);
    tsd_hot = 1'b0;
    step();
    chk("R8 error clear", {therm_err, err_drive}, 32'd0);
    tick(); tick();
    chk("R8 not resumed", 32'(ch_on), 32'd0);
    restart();
    tick();
    chk("R8 new cycle", 32'(ch_on), 32'hFFFE);

    // R8 flag still set when blanking falls
    blank = 1'b1;
    tsd_hot = 1'b1;
    step();
    blank = 1'b0;
    step();
    tick();
    chk("R8 blocked start", 32'(ch_on), 32'd0);
    tsd_hot = 1'b0;
    step();
    tick();
    chk("R8 start after clear", 32'(ch_on), 32'hFFFE);

    // R9 / R10 warning
    warn_hot = 1'b1;
    step();
    chk("R9 warn set", {warn_flag, therm_err}, 32'd2);
    chk("R10 drive", 32'(err_drive), 32'd1);
    chk("R9 outputs kept", 32'(ch_on), 32'hFFFE);
    warn_hot = 1'b0;
    step();
    chk("R9 warn clear", 32'(warn_flag), 32'd0);
    chk("R10 release", 32'(err_drive), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule